// File: doc/BRIEF.md
# SRAM Write Timing Monitor

This block watches the chip-enable, write-enable, address and data pins of an asynchronous static RAM. It samples them with a fast system clock and reports every write whose timing breaks one of seven rules. A write is in progress while both active-low strobes are low. It begins on the sample where the second strobe falls and ends on the sample where the first strobe rises. Each interval is measured in whole clock ticks. The resolution is therefore one clock period. Every limit is a nanosecond value rounded up to ticks.

Each broken rule sets its own sticky flag. A flag stays set until software writes a one to its bit in the clear mask. The monitor also keeps the smallest value ever measured for pulse width, data setup, address setup and write-to-write spacing. All of these are read through a small select-and-read port. A static input chooses between the fast and the slow limit set.

The pin samples pass through a two-flop synchronizer, and all edges are found on the synchronized values. Every interval counter is 16 bits wide and saturates at its maximum, so a long idle time never wraps around. A three-state controller tracks the pins. IDLE moves to WRITE on a write start (transition "start"). WRITE moves to RECOVER on a write end (transition "end"), or straight to IDLE when the address changes on the end sample (transition "end_with_move"). RECOVER moves to WRITE on the next start (transition "restart"), or to IDLE on the first address change (transition "move").

Top module: `sram_wr_monitor`

## Requirements
- R1: After reset, every flag bit reads 0 and all four worst-value registers read 0xFFFF.
- R2: On a write end, if fewer ticks than ceil(65 ns / clock) (fast) or ceil(85 ns / clock) (slow) have passed since the write start, flag bit 0 is set.
- R3: On a write end, if fewer ticks than ceil(35 ns) (fast) or ceil(45 ns) (slow) have passed since the last data change, flag bit 1 is set.
- R4: On a write end, if fewer ticks than ceil(75 ns) (fast) or ceil(100 ns) (slow) have passed since the last address change, flag bit 2 is set.
- R5: An address change on a sample inside a write, other than the end sample, sets flag bit 3.
- R6: The recovery check covers the first address change from the end sample up to the next write start. It fails, and sets flag bit 4, unless WE has been high for at least ceil(5 ns) ticks or CE has been high for at least ceil(15 ns) ticks.
- R7: The hold check covers a data change in the same window. It fails, and sets flag bit 5, unless WE has been high for at least ceil(0 ns) ticks or CE has been high for at least ceil(10 ns) ticks.
- R8: A write start that comes fewer than ceil(85 ns) (fast) or ceil(120 ns) (slow) ticks after the previous write start sets flag bit 6.
- R9: Flag bits are sticky. A bit clears only in a cycle where clr_en is high and its clr_mask bit is 1. Bits outside the mask keep their value.
- R10: rd_sel chooses what rd_data shows: 0 gives the flags, 1 the smallest pulse width, 2 the smallest data setup, 3 the smallest address setup, 4 the smallest start-to-start spacing. All values are in ticks.
- R11: speed_slow set to 1 selects the slow limits. Set to 0, it selects the fast limits.
- R12: Interval counters saturate at 0xFFFF. A write after more than 65535 idle ticks records 0xFFFF and not a wrapped value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| speed_slow | input | 1 | Limit set select, 1 = slow |
| ce_n | input | 1 | Observed chip enable, active low |
| we_n | input | 1 | Observed write enable, active low |
| addr | input | AW | Observed address bus |
| data | input | DW | Observed data bus |
| clr_en | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | 7 | Flag bits to clear |
| rd_sel | input | 3 | Read register select |
| rd_data | output | 16 | Selected register value |

## Verification
The bench targets the samples that sit exactly on a write end. An address change there must count as a recovery failure and not as a move during the write; a design that mixed the two would set bit 3 instead of bit 4. A data change on the end sample must pass when WE ends the write but fail when CE ends it; a design that ignored which strobe rose would get one of the two cases wrong. Two further checks cover back-to-back writes separated by a single idle tick, which exposes a start-to-start counter that is not restarted, and a 66000-tick idle stretch that exposes a counter that wraps instead of saturating.

// File: rtl/sram_wrmon_pkg.sv
package sram_wrmon_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WRITE   = 2'd1,
        ST_RECOVER = 2'd2
    } mon_state_t;

    localparam int NFLAG   = 7;
    localparam int FL_PW   = 0;
    localparam int FL_DS   = 1;
    localparam int FL_AS   = 2;
    localparam int FL_AMOV = 3;
    localparam int FL_REC  = 4;
    localparam int FL_HOLD = 5;
    localparam int FL_CYC  = 6;

    function automatic int ns2tick(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

endpackage

// File: rtl/wrmon_sync.sv
module wrmon_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            dout   <= RST_VAL;
        end else begin
            meta_q <= din;
            dout   <= meta_q;
        end
    end
endmodule

// File: rtl/wrmon_satcnt.sv
module wrmon_satcnt #(
    parameter int W = 16,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         clear,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= INIT;
        else if (restart)      cnt <= ONE;
        else if (clear)        cnt <= '0;
        else if (cnt != MAXV)  cnt <= cnt + ONE;
    end

    // R12: a full counter stays full until restarted or cleared
    assert_sat_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAXV && !restart && !clear) |=> (cnt == MAXV));
endmodule

// File: rtl/sram_wr_monitor.sv
module sram_wr_monitor
    import sram_wrmon_pkg::*;
#(
    parameter int AW     = 18,
    parameter int DW     = 8,
    parameter int CNT_W  = 16,
    parameter int CLK_NS = 20,
    parameter int PW_F_NS = 65,  parameter int PW_S_NS = 85,
    parameter int DS_F_NS = 35,  parameter int DS_S_NS = 45,
    parameter int AS_F_NS = 75,  parameter int AS_S_NS = 100,
    parameter int WC_F_NS = 85,  parameter int WC_S_NS = 120,
    parameter int REC_WE_NS = 5, parameter int REC_CE_NS = 15,
    parameter int HLD_WE_NS = 0, parameter int HLD_CE_NS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             speed_slow,
    input  logic             ce_n,
    input  logic             we_n,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    data,
    input  logic             clr_en,
    input  logic [NFLAG-1:0] clr_mask,
    input  logic [2:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data
);
    localparam logic [CNT_W-1:0] PW_F = CNT_W'(ns2tick(PW_F_NS, CLK_NS));
    localparam logic [CNT_W-1:0] PW_S = CNT_W'(ns2tick(PW_S_NS, CLK_NS));
    localparam logic [CNT_W-1:0] DS_F = CNT_W'(ns2tick(DS_F_NS, CLK_NS));
    localparam logic [CNT_W-1:0] DS_S = CNT_W'(ns2tick(DS_S_NS, CLK_NS));
    localparam logic [CNT_W-1:0] AS_F = CNT_W'(ns2tick(AS_F_NS, CLK_NS));
    localparam logic [CNT_W-1:0] AS_S = CNT_W'(ns2tick(AS_S_NS, CLK_NS));
    localparam logic [CNT_W-1:0] WC_F = CNT_W'(ns2tick(WC_F_NS, CLK_NS));
    localparam logic [CNT_W-1:0] WC_S = CNT_W'(ns2tick(WC_S_NS, CLK_NS));
    localparam logic [CNT_W-1:0] RW_T = CNT_W'(ns2tick(REC_WE_NS, CLK_NS));
    localparam logic [CNT_W-1:0] RC_T = CNT_W'(ns2tick(REC_CE_NS, CLK_NS));
    localparam logic [CNT_W-1:0] HW_T = CNT_W'(ns2tick(HLD_WE_NS, CLK_NS));
    localparam logic [CNT_W-1:0] HC_T = CNT_W'(ns2tick(HLD_CE_NS, CLK_NS));
    localparam logic [CNT_W-1:0] CMAX = '1;

    // synchronized pins and previous samples
    logic          ce_s, we_s, ce_p, we_p;
    logic [AW-1:0] a_s, a_p;
    logic [DW-1:0] d_s, d_p;

    wrmon_sync #(.W(2), .RST_VAL(2'b11)) u_sync_stb (
        .clk(clk), .rst_n(rst_n), .din({ce_n, we_n}), .dout({ce_s, we_s}));
    wrmon_sync #(.W(AW+DW), .RST_VAL('0)) u_sync_bus (
        .clk(clk), .rst_n(rst_n), .din({addr, data}), .dout({a_s, d_s}));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_p <= 1'b1;
            we_p <= 1'b1;
            a_p  <= '0;
            d_p  <= '0;
        end else begin
            ce_p <= ce_s;
            we_p <= we_s;
            a_p  <= a_s;
            d_p  <= d_s;
        end
    end

    logic act_s, act_p, wr_start, wr_end, a_chg, d_chg, we_rise, ce_rise;
    assign act_s    = ~ce_s & ~we_s;
    assign act_p    = ~ce_p & ~we_p;
    assign wr_start = act_s & ~act_p;
    assign wr_end   = ~act_s & act_p;
    assign a_chg    = (a_s != a_p);
    assign d_chg    = (d_s != d_p);
    assign we_rise  = we_s & ~we_p;
    assign ce_rise  = ce_s & ~ce_p;

    // interval counters
    logic [CNT_W-1:0] pw_c, dv_c, av_c, wc_c, we_c, ce_c;

    wrmon_satcnt #(.W(CNT_W), .INIT('0)) u_cnt_pw (
        .clk(clk), .rst_n(rst_n), .restart(wr_start), .clear(1'b0), .cnt(pw_c));
    wrmon_satcnt #(.W(CNT_W), .INIT('0)) u_cnt_dv (
        .clk(clk), .rst_n(rst_n), .restart(d_chg), .clear(1'b0), .cnt(dv_c));
    wrmon_satcnt #(.W(CNT_W), .INIT('0)) u_cnt_av (
        .clk(clk), .rst_n(rst_n), .restart(a_chg), .clear(1'b0), .cnt(av_c));
    wrmon_satcnt #(.W(CNT_W), .INIT(CMAX)) u_cnt_wc (
        .clk(clk), .rst_n(rst_n), .restart(wr_start), .clear(1'b0), .cnt(wc_c));
    wrmon_satcnt #(.W(CNT_W), .INIT('0)) u_cnt_we (
        .clk(clk), .rst_n(rst_n), .restart(we_rise), .clear(~we_s), .cnt(we_c));
    wrmon_satcnt #(.W(CNT_W), .INIT('0)) u_cnt_ce (
        .clk(clk), .rst_n(rst_n), .restart(ce_rise), .clear(~ce_s), .cnt(ce_c));

    // limit set
    logic [CNT_W-1:0] lim_pw, lim_ds, lim_as, lim_wc;
    always_comb begin
        lim_pw = speed_slow ? PW_S : PW_F;
        lim_ds = speed_slow ? DS_S : DS_F;
        lim_as = speed_slow ? AS_S : AS_F;
        lim_wc = speed_slow ? WC_S : WC_F;
    end

    // state register
    mon_state_t state_q, state_d;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (wr_start) state_d = ST_WRITE;
            ST_WRITE:   if (wr_end)   state_d = a_chg ? ST_IDLE : ST_RECOVER;
            ST_RECOVER: if (wr_start) state_d = ST_WRITE;
                        else if (a_chg) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // violation detection
    logic             in_write, end_now, rec_zone, rec_ok, hold_ok;
    logic [NFLAG-1:0] set_vec, clr_vec, flags_q;

    always_comb begin
        in_write = (state_q == ST_WRITE);
        end_now  = in_write & wr_end;
        rec_zone = end_now | ((state_q == ST_RECOVER) & ~wr_start);
        rec_ok   = (we_s && we_c >= RW_T) || (ce_s && ce_c >= RC_T);
        hold_ok  = (we_s && we_c >= HW_T) || (ce_s && ce_c >= HC_T);
        set_vec  = '0;
        set_vec[FL_PW]   = end_now && (pw_c < lim_pw);
        set_vec[FL_DS]   = end_now && (dv_c < lim_ds);
        set_vec[FL_AS]   = end_now && (av_c < lim_as);
        set_vec[FL_AMOV] = in_write && a_chg && !wr_end;
        set_vec[FL_REC]  = rec_zone && a_chg && !rec_ok;
        set_vec[FL_HOLD] = rec_zone && d_chg && !hold_ok;
        set_vec[FL_CYC]  = wr_start && (wc_c < lim_wc);
        clr_vec = clr_en ? clr_mask : '0;
    end

    // sticky flags and worst-value log
    logic [CNT_W-1:0] worst_pw_q, worst_dv_q, worst_av_q, worst_wc_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q    <= '0;
            worst_pw_q <= CMAX;
            worst_dv_q <= CMAX;
            worst_av_q <= CMAX;
            worst_wc_q <= CMAX;
        end else begin
            flags_q <= (flags_q & ~clr_vec) | set_vec;
            if (end_now) begin
                if (pw_c < worst_pw_q) worst_pw_q <= pw_c;
                if (dv_c < worst_dv_q) worst_dv_q <= dv_c;
                if (av_c < worst_av_q) worst_av_q <= av_c;
            end
            if (wr_start && wc_c < worst_wc_q) worst_wc_q <= wc_c;
        end
    end

    always_comb begin
        unique case (rd_sel)
            3'd0:    rd_data = CNT_W'(flags_q);
            3'd1:    rd_data = worst_pw_q;
            3'd2:    rd_data = worst_dv_q;
            3'd3:    rd_data = worst_av_q;
            3'd4:    rd_data = worst_wc_q;
            default: rd_data = '0;
        endcase
    end

    // R9: a set flag survives unless its clear bit was strobed
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(flags_q) & ~$past(clr_vec)) & ~flags_q) == '0));

    // R2: the write state is only held while the strobes overlapped on the prior sample
    assert_write_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE) |-> $past(act_s));

    // R10: the smallest pulse width never grows
    assert_worst_mono_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (worst_pw_q <= $past(worst_pw_q)));

    // R8: a too-early start is visible in the flags one cycle later
    assert_cycle_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_start && wc_c < lim_wc) |=> flags_q[FL_CYC]);
endmodule

// File: tb/sram_wr_monitor_bench.sv
module sram_wr_monitor_bench;
    localparam int AW = 8;
    localparam int DW = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       speed_slow = 1'b0;
    logic       ce_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data = '0;
    logic       clr_en = 1'b0;
    logic [6:0] clr_mask = '0;
    logic [2:0] rd_sel = '0;
    logic [15:0] rd_data;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int min_pw = 65535, min_dw = 65535, min_aw = 65535;

    always #10 clk = ~clk;

    sram_wr_monitor #(.AW(AW), .DW(DW)) u_sram_wr_monitor (
        .clk(clk), .rst_n(rst_n), .speed_slow(speed_slow), .ce_n(ce_n), .we_n(we_n),
        .addr(addr), .data(data), .clr_en(clr_en), .clr_mask(clr_mask),
        .rd_sel(rd_sel), .rd_data(rd_data));

    function automatic int tk(input int ns);
        return (ns + 19) / 20;
    endfunction

    function automatic int umin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic [15:0] exp_flags(input int aw, input int pw, input int dw,
            input bit by_ce, input int grec, input int ghold, input int mid, input bit slow);
        logic [15:0] f = '0;
        int av = (mid >= 0) ? aw - mid : aw;
        f[0] = pw < tk(slow ? 85 : 65);
        f[1] = dw < tk(slow ? 45 : 35);
        f[2] = av < tk(slow ? 100 : 75);
        f[3] = (mid >= 0);
        f[4] = (grec == 0);
        f[5] = (ghold <= grec) && (ghold == 0) && by_ce;
        return f;
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic step(input logic c, input logic w);
        @(negedge clk);
        ce_n = c;
        we_n = w;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [15:0] v);
        @(negedge clk);
        rd_sel = sel;
        #1 v = rd_data;
    endtask

    task automatic clear(input logic [6:0] m);
        @(negedge clk);
        clr_en = 1'b1;
        clr_mask = m;
        @(negedge clk);
        clr_en = 1'b0;
        clr_mask = '0;
    endtask

    task automatic run_write(input int aw, input int pw, input int dw, input bit by_ce,
                             input int grec, input int ghold, input int mid);
        logic [DW-1:0] nd = data ^ (DW'($urandom) | DW'(1));
        int last = aw + ((grec > ghold) ? grec : ghold);
        for (int t = 0; t <= last; t++) begin
            @(negedge clk);
            if (t == 0)              addr = addr + 1'b1;
            if (t == mid)            addr = addr + 8'd3;
            if (t == aw + grec)      addr = addr + 8'd7;
            if (t == aw - dw)        data = nd;
            if (t == aw + ghold)     data = data ^ 8'h5A;
            if (t < aw) begin
                ce_n = !(t >= aw - pw);
                we_n = !(t >= aw - pw);
            end else begin
                ce_n = by_ce;
                we_n = !by_ce;
            end
        end
        step(1'b1, 1'b1);
        repeat (10) @(negedge clk);
        min_pw = umin(min_pw, pw);
        min_dw = umin(min_dw, dw);
        min_aw = umin(min_aw, (mid >= 0) ? aw - mid : aw);
    endtask

    initial begin
        logic [15:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        rd(3'd0, v); check("R1 flags", v, 16'h0);
        for (int s = 1; s <= 4; s++) begin
            rd(3'(s), v); check("R1 worst", v, 16'hFFFF);
        end

        // R12 long idle then a clean write, no bus change
        repeat (66000) @(negedge clk);
        for (int t = 0; t < 5; t++) step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        repeat (8) @(negedge clk);
        min_pw = 5;
        rd(3'd0, v); check("R12 flags", v, 16'h0);
        rd(3'd3, v); check("R12 addr saturate", v, 16'hFFFF);
        rd(3'd2, v); check("R12 data saturate", v, 16'hFFFF);
        rd(3'd1, v); check("R10 worst pw", v, 16'd5);

        // R6 address move on end sample, WE ends
        run_write(6, 5, 3, 1'b0, 0, 2, -1);
        rd(3'd0, v); check("R6 end-sample move", v, exp_flags(6, 5, 3, 0, 0, 2, -1, 0));
        clear(7'h7F);

        // R7 data change on end sample, CE ends: fails
        run_write(6, 5, 3, 1'b1, 2, 0, -1);
        rd(3'd0, v); check("R7 hold ce end", v, 16'h0020);
        clear(7'h7F);

        // R7 data change on end sample, WE ends: passes
        run_write(6, 5, 3, 1'b0, 2, 0, -1);
        rd(3'd0, v); check("R7 hold we end", v, 16'h0000);
        clear(7'h7F);

        // R5 and R4 address move inside write
        run_write(6, 4, 3, 1'b0, 2, 3, 4);
        rd(3'd0, v); check("R5 move in write", v, 16'h000C);
        clear(7'h7F);

        // R11 slow limits: pw 4 fails slow, passes fast
        speed_slow = 1'b1;
        run_write(6, 4, 3, 1'b0, 1, 2, -1);
        rd(3'd0, v); check("R11 slow", v, exp_flags(6, 4, 3, 0, 1, 2, -1, 1));
        clear(7'h7F);
        speed_slow = 1'b0;
        run_write(6, 4, 3, 1'b0, 1, 2, -1);
        rd(3'd0, v); check("R11 fast", v, 16'h0);

        // R9 sticky and masked clear
        run_write(6, 2, 3, 1'b0, 1, 2, -1);
        run_write(6, 5, 3, 1'b0, 1, 2, -1);
        rd(3'd0, v); check("R9 sticky", v, 16'h0001);
        clear(7'h40);
        rd(3'd0, v); check("R9 masked keep", v, 16'h0001);
        clear(7'h01);
        rd(3'd0, v); check("R9 cleared", v, 16'h0000);

        // R8 back-to-back writes one tick apart; R2 short first pulse
        for (int t = 0; t < 3; t++) step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        for (int t = 0; t < 4; t++) step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        repeat (10) @(negedge clk);
        min_pw = umin(min_pw, 3);
        rd(3'd0, v); check("R8 cycle and R2 pw", v, 16'h0041);
        rd(3'd4, v); check("R8 worst spacing", v, 16'd4);
        clear(7'h7F);

        // random writes: R2 R3 R4 R6 R7 R11
        for (int i = 0; i < 60; i++) begin
            int aw = $urandom_range(8, 1);
            int pw = $urandom_range(aw, 1);
            int dw = $urandom_range(aw, 1);
            bit bc = 1'($urandom);
            int gr = $urandom_range(3, 0);
            int gh = $urandom_range(3, 0);
            speed_slow = 1'($urandom);
            run_write(aw, pw, dw, bc, gr, gh, -1);
            rd(3'd0, v);
            check("R2 R3 R4 R6 R7 random", v, exp_flags(aw, pw, dw, bc, gr, gh, -1, speed_slow));
            clear(7'h7F);
        end

        // R10 worst-value log
        rd(3'd1, v); check("R10 pw min", v, 16'(min_pw));
        rd(3'd2, v); check("R10 dw min", v, 16'(min_dw));
        rd(3'd3, v); check("R10 aw min", v, 16'(min_aw));
        rd(3'd5, v); check("R10 unused sel", v, 16'h0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule